// File: doc/BRIEF.md
# Four-Wire Serial Command/Data Receiver

This block is the write-only serial front end of a display controller. A host drives a serial clock, a serial data line, a command/data select line and an active-low chip select. Bits are gathered into bytes most significant bit first, on rising serial clock edges. The select line is looked at only when the eighth bit of a byte arrives. That one sample decides whether the finished byte is a command or a display data byte.

Each finished byte crosses into the system clock domain through a toggle synchronizer. There it appears as a one-cycle write strobe, together with the byte and a flag that tells command from data. A display-memory write address comes out beside the strobe. It starts at zero and steps by one after every data byte. Command bytes leave it alone.

Raising chip select clears the bit count, so a partly sent byte is dropped. Any number of bytes may follow one another inside a single chip-select window. The system clock must run at least four times faster than the serial clock.

Top module: `spi_cmd_data_rx`

## Requirements
- R1: Serial data is sampled on each rising edge of `spi_sck` while `spi_cs_n` is low. The first bit sampled becomes bit 7 of the byte and the eighth becomes bit 0.
- R2: `spi_dc` is sampled only on the eighth rising edge of a byte. Low there gives `wr_is_data` = 0 (command) and high gives `wr_is_data` = 1 (display data). Its level on the other seven edges has no effect.
- R3: Each completed byte produces exactly one `wr_stb` pulse, one system clock wide, with `wr_byte` and `wr_is_data` valid in that cycle. The pulse comes no more than SYNC_STAGES+3 system clocks after the eighth edge.
- R4: When `spi_cs_n` goes high the bit count returns to zero. A byte with fewer than eight bits is discarded and produces no strobe. The next byte starts cleanly after chip select falls again.
- R5: Several bytes sent back to back within one chip-select low window each produce their own strobe, in the order they were sent.
- R6: Rising edges of `spi_sck` while `spi_cs_n` is high produce no strobe.
- R7: `wr_addr` is the address for the current data strobe. It advances by one in the cycle after each data strobe and wraps from 2^ADDR_W-1 to 0. Command strobes leave it unchanged.
- R8: While `rst_n` is low, `wr_stb` is 0 and `wr_addr` is 0 at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; synchronous for system-domain state, also clears the serial-side handoff register |
| spi_sck | input | 1 | Serial clock from host, rising edge samples |
| spi_mosi | input | 1 | Serial data from host, MSB first |
| spi_dc | input | 1 | Command (low) / data (high) select, sampled on the eighth bit |
| spi_cs_n | input | 1 | Active-low chip select |
| wr_stb | output | 1 | One-cycle write strobe per received byte |
| wr_byte | output | 8 | Received byte, valid with `wr_stb` |
| wr_is_data | output | 1 | 1 for display data, 0 for command, valid with `wr_stb` |
| wr_addr | output | ADDR_W | Display-memory write address for data strobes |

## Verification
The assertions check these properties on every cycle:
- The serial-side handoff toggle changes only on the last bit of a byte.
- The strobe never lasts two cycles.
- The address steps by exactly one after a data strobe and holds otherwise.
- Reset forces the strobe low and the address to zero.

Only the bench's scenarios can show the following:
- That byte values come out in MSB-first order.
- That the select line counts only on the eighth edge, even when it changes during a byte.
- That a partial byte cut off by chip select is dropped.
- That clock edges outside chip select are ignored.
- That the address wraps after a long data stream.

// File: rtl/spi_rx_pkg.sv
// Package: shared types and constants for the serial command/data receiver.
// Assumes bytes are eight bits and carry one command/data flag.
package spi_rx_pkg;

    localparam int BYTE_W = 8;

    // One received byte plus its destination flag.
    typedef struct packed {
        logic                is_data;
        logic [BYTE_W-1:0]   value;
    } rx_word_t;

endpackage

// File: rtl/spi_rx_shift.sv
// Module: spi_rx_shift
// Serial-clock domain capture. Shifts the data line in MSB first and counts
// bits. On the last bit of each byte it stores the byte and the select line
// in a handoff register and flips a toggle.
// Assumes: the chip select high level asynchronously clears the bit count.
// The handoff register is reset by the system reset, because the serial
// clock is not running while chip select is high.
module spi_rx_shift
    import spi_rx_pkg::*;
(
    input  logic     rst_n,
    input  logic     sck,
    input  logic     cs_n,
    input  logic     mosi,
    input  logic     dc,
    output rx_word_t held,
    output logic     done_tog
);

    localparam int                CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] shreg;
    logic              last;

    assign last = (bit_cnt == LAST_BIT);

    // Bit counter and shift register, cleared while chip select is high.
    always_ff @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            bit_cnt <= last ? '0 : bit_cnt + 1'b1;
            shreg   <= {shreg[BYTE_W-3:0], mosi};
        end
    end

    // Handoff register and toggle, loaded on the last bit of each byte.
    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) begin
            held     <= '0;
            done_tog <= 1'b0;
        end else if (last) begin
            held.value   <= {shreg, mosi};
            held.is_data <= dc;
            done_tog     <= ~done_tog;
        end
    end

    // R5: the toggle only moves on the final bit of a byte.
    a_r5_toggle_on_last_bit: assert property (
        @(posedge sck) disable iff (!rst_n || cs_n)
        !last |=> $stable(done_tog)
    );

endmodule

// File: rtl/spi_rx_toggle_sync.sv
// Module: spi_rx_toggle_sync
// System-domain half of the byte crossing. It synchronizes the handoff toggle
// through STAGES flops and turns each change into one strobe. The handoff
// word is captured in the same cycle.
// Assumes: the handoff word is stable for at least STAGES+2 system clocks
// after the toggle moves. This holds when the system clock runs at least
// four times faster than the serial clock. STAGES must be 2 or more.
module spi_rx_toggle_sync
    import spi_rx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tog_in,
    input  rx_word_t word_in,
    output logic     stb,
    output rx_word_t word_out
);

    logic [STAGES-1:0] chain;
    logic              seen;
    logic              flip;

    assign flip = chain[STAGES-1] ^ seen;

    // Synchronizer chain plus a copy of the last settled toggle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            seen  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], tog_in};
            seen  <= chain[STAGES-1];
        end
    end

    // Strobe generation and capture of the settled handoff word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb      <= 1'b0;
            word_out <= '0;
        end else begin
            stb <= flip;
            if (flip) begin
                word_out <= word_in;
            end
        end
    end

    // R3: a strobe is never wider than one cycle.
    a_r3_single_pulse: assert property (
        @(posedge clk) disable iff (!rst_n)
        stb |=> !stb
    );

endmodule

// File: rtl/spi_rx_wr_ptr.sv
// Module: spi_rx_wr_ptr
// Display-memory write pointer. Steps by one after each data write and
// wraps at 2**ADDR_W.
// Assumes: adv is a single-cycle pulse taken from the data strobe.
module spi_rx_wr_ptr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr
);

    // Pointer register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (adv) begin
            addr <= addr + 1'b1;
        end
    end

    // R7: one step after a data write, including the wrap to zero.
    a_r7_addr_step: assert property (
        @(posedge clk) disable iff (!rst_n)
        adv |=> (addr == $past(addr) + 1'b1)
    );

    // R7: no movement without a data write.
    a_r7_addr_hold: assert property (
        @(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(addr)
    );

endmodule

// File: rtl/spi_cmd_data_rx.sv
// Module: spi_cmd_data_rx (top)
// Four-wire serial receiver. It assembles bytes in the serial clock domain
// and hands each one to the system clock domain as a single-cycle write
// strobe with a command/data flag. It also keeps the display-memory write
// address for data bytes.
// Assumes: the system clock runs at least four times faster than the
// serial clock.
module spi_cmd_data_rx
    import spi_rx_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_dc,
    input  logic              spi_cs_n,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              wr_is_data,
    output logic [ADDR_W-1:0] wr_addr
);

    rx_word_t handoff;
    rx_word_t settled;
    logic     handoff_tog;

    spi_rx_shift u_shift (
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .dc       (spi_dc),
        .held     (handoff),
        .done_tog (handoff_tog)
    );

    spi_rx_toggle_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tog_in   (handoff_tog),
        .word_in  (handoff),
        .stb      (wr_stb),
        .word_out (settled)
    );

    assign wr_byte    = settled.value;
    assign wr_is_data = settled.is_data;

    spi_rx_wr_ptr #(
        .ADDR_W (ADDR_W)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (wr_stb & wr_is_data),
        .addr  (wr_addr)
    );

    // R8: reset silences the strobe and clears the address.
    a_r8_reset_quiet: assert property (
        @(posedge clk)
        !rst_n |=> (!wr_stb && wr_addr == '0)
    );

endmodule

// File: tb/spi_cmd_data_rx_bench.sv
// Bench for spi_cmd_data_rx. A behavioural host model drives the serial
// lines and pushes each expected byte into a queue on its eighth edge.
// Every system clock the outputs are compared against the queue front.
module spi_cmd_data_rx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SCK_HALF   = 40;
    localparam int ADDR_W     = 4;
    localparam int SYNC       = 2;
    localparam int MAX_LAT    = (SYNC + 3) * CLK_PERIOD;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              spi_sck = 1'b0;
    logic              spi_mosi = 1'b0;
    logic              spi_dc = 1'b0;
    logic              spi_cs_n = 1'b1;
    logic              wr_stb;
    logic [7:0]        wr_byte;
    logic              wr_is_data;
    logic [ADDR_W-1:0] wr_addr;

    int checks = 0;
    int fails  = 0;
    int strobes_seen = 0;
    int model_addr = 0;
    int host_bits = 0;
    logic [7:0] host_byte = 8'h00;
    logic [8:0] exp_q[$];
    time        exp_t[$];
    logic       prev_stb = 1'b0;
    logic       run_done = 1'b0;

    spi_cmd_data_rx #(
        .ADDR_W      (ADDR_W),
        .SYNC_STAGES (SYNC)
    ) u_spi_cmd_data_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sck    (spi_sck),
        .spi_mosi   (spi_mosi),
        .spi_dc     (spi_dc),
        .spi_cs_n   (spi_cs_n),
        .wr_stb     (wr_stb),
        .wr_byte    (wr_byte),
        .wr_is_data (wr_is_data),
        .wr_addr    (wr_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the behavioural model.
    always @(negedge clk) begin
        if (rst_n && !run_done) begin
            if (wr_stb) begin
                strobes_seen++;
                check(!prev_stb, "R3", "strobe wider than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected strobe", int'(wr_byte), -1);
                end else begin
                    logic [8:0] e;
                    time        t0;
                    e  = exp_q.pop_front();
                    t0 = exp_t.pop_front();
                    check(wr_byte == e[7:0], "R1", "byte value", int'(wr_byte), int'(e[7:0]));
                    check(wr_is_data == e[8], "R2", "command/data flag", int'(wr_is_data), int'(e[8]));
                    check(($time - t0) <= MAX_LAT, "R3", "strobe latency",
                          int'($time - t0), MAX_LAT);
                    if (e[8]) begin
                        check(wr_addr == ADDR_W'(model_addr), "R7", "write address",
                              int'(wr_addr), model_addr % (1 << ADDR_W));
                        model_addr++;
                    end
                end
            end else if (exp_q.size() != 0 && ($time - exp_t[0]) > MAX_LAT) begin
                logic [8:0] lost;
                lost = exp_q.pop_front();
                void'(exp_t.pop_front());
                check(1'b0, "R3", "byte never strobed", -1, int'(lost[7:0]));
            end
            prev_stb = wr_stb;
        end
    end

    // One serial bit; the host model counts bits and queues whole bytes.
    task automatic sck_bit(input logic b, input logic d);
        spi_mosi = b;
        spi_dc   = d;
        #SCK_HALF;
        spi_sck = 1'b1;
        if (!spi_cs_n) begin
            host_byte = {host_byte[6:0], b};
            host_bits++;
            if (host_bits % 8 == 0) begin
                exp_q.push_back({d, host_byte});
                exp_t.push_back($time);
            end
        end
        #SCK_HALF;
        spi_sck = 1'b0;
    endtask

    // Whole byte; dc_wrong drives the opposite select level on bits 7..1.
    task automatic send_byte(input logic d, input logic [7:0] v, input bit dc_wrong);
        for (int i = 7; i >= 0; i--) begin
            sck_bit(v[i], (dc_wrong && i != 0) ? ~d : d);
        end
    endtask

    task automatic cs_low();
        #SCK_HALF;
        spi_cs_n = 1'b0;
        #SCK_HALF;
    endtask

    task automatic cs_high();
        #SCK_HALF;
        spi_cs_n  = 1'b1;
        host_bits = 0;
        #SCK_HALF;
    endtask

    task automatic settle(input string req);
        repeat (SYNC + 6) @(negedge clk);
        check(exp_q.size() == 0, req, "bytes still pending", exp_q.size(), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R8: reset state.
        check(wr_stb == 1'b0, "R8", "strobe in reset", int'(wr_stb), 0);
        check(wr_addr == '0, "R8", "address in reset", int'(wr_addr), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #2;

        // R1 R2 R5: command then two data bytes in one window.
        cs_low();
        send_byte(1'b0, 8'hA5, 1'b0);
        send_byte(1'b1, 8'h3C, 1'b0);
        send_byte(1'b1, 8'h81, 1'b0);
        cs_high();
        settle("R5");
        check(strobes_seen == 3, "R5", "strobes for three bytes", strobes_seen, 3);

        // R2: select level wrong on all but the eighth bit.
        cs_low();
        send_byte(1'b1, 8'h5A, 1'b1);
        send_byte(1'b0, 8'h0F, 1'b1);
        cs_high();
        settle("R2");

        // R4: partial byte dropped, next byte clean.
        cs_low();
        for (int i = 0; i < 5; i++) sck_bit(1'b1, 1'b1);
        cs_high();
        cs_low();
        send_byte(1'b1, 8'hC3, 1'b0);
        cs_high();
        settle("R4");
        check(strobes_seen == 6, "R4", "strobe count after partial byte", strobes_seen, 6);

        // R6: clock edges with chip select high.
        for (int i = 0; i < 12; i++) sck_bit(i[0], 1'b1);
        settle("R6");
        check(strobes_seen == 6, "R6", "strobes while deselected", strobes_seen, 6);

        // R7: long data stream with a command inside, address wraps.
        cs_low();
        for (int i = 0; i < 18; i++) begin
            send_byte(1'b1, 8'(i * 7 + 1), 1'b0);
            if (i == 9) send_byte(1'b0, 8'hE2, 1'b0);
        end
        cs_high();
        settle("R7");
        repeat (2) @(negedge clk);
        check(wr_addr == ADDR_W'(model_addr), "R7", "address after stream",
              int'(wr_addr), model_addr % (1 << ADDR_W));

        run_done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!run_done) begin
            run_done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule